// File: doc/BRIEF.md
# Fixed-Point Store Address and Data Unit

This block turns one decoded integer store operation into one memory write request. It takes an operation code, three register operands (base, index and source), a flag saying whether the base register field names register zero, and a 16-bit displacement. From these it forms the effective address, a byte-enable mask and the write data placed on a 64-bit big-endian bus. For update forms, it also asks for the effective address to be written back into the base register. Encodings with no legal meaning are not turned into stores. Instead they are returned with an illegal-form flag.

The operation code is five bits. Bits [1:0] give the access size: 0 is byte, 1 is halfword, 2 is word and 3 is doubleword. Bits [4:2] give the form: 0 is base plus displacement, 1 is base plus index, 2 is update with displacement, 3 is update with index, and 4 is byte-reversed with index. Form codes 5 to 7 are illegal. One request is taken in through a valid/ready handshake and held in a single output register stage until the consumer accepts it.

Top module: `stu_top`

## Requirements
- R1: In forms 0, 1 and 4, the base is zero when `ra_zero` is 1 and `ra_val` otherwise. Update forms (2 and 3) always use `ra_val` as the base.
- R2: `out_addr` equals the base plus an offset, taken modulo 2^64. The offset is `rb_val` in forms 1, 3 and 4. In forms 0 and 2 it is the sign-extended displacement.
- R3: For doubleword size in forms 0 and 2, displacement bits [1:0] are ignored, so the offset is the sign-extended displacement with its two low bits cleared.
- R4: In update forms that are not illegal, `out_wb_en` is 1, which asks for `out_addr` to be written into the base register. In every other case it is 0.
- R5: Any of the following sets `out_illegal` to 1: form 5, 6 or 7; an update form with `ra_zero` set; or form 4 with byte size. An illegal result carries `out_be` = 0, `out_data` = 0 and `out_wb_en` = 0.
- R6: A legal store writes the low 1, 2, 4 or 8 bytes of `rs_val`. In non-reversed forms the most significant of those bytes goes to the lowest memory address. Memory byte j of the aligned doubleword sits on lane 7-j, which is bits [8(7-j)+7 : 8(7-j)] of `out_data` and bit 7-j of `out_be`. Unwritten lanes are 0.
- R7: Form 4 stores the same bytes in reverse order: the least significant byte of `rs_val` goes to the lowest memory address.
- R8: `in_ready` is 1 when the output stage is empty or `out_ready` is 1. A request is taken on a clock edge where `in_valid` and `in_ready` are both 1, and it appears on the outputs after that edge. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R9: During reset, `out_valid` is 0 and `in_ready` is 1.
- R10: The lane offset is `out_addr[2:0]` with the bits below the access size cleared. Address bits below the access size therefore do not move the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A store operation is offered |
| in_ready | output | 1 | The unit can take an operation |
| op | input | 5 | [4:2] form, [1:0] size |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| rs_val | input | 64 | Source register contents |
| ra_zero | input | 1 | The base register field is zero |
| disp | input | 16 | Signed displacement |
| out_valid | output | 1 | A request is present |
| out_ready | input | 1 | The consumer takes the request |
| out_addr | output | 64 | Effective address |
| out_be | output | 8 | Byte enables, bit i for lane i |
| out_data | output | 64 | Write data in big-endian lanes |
| out_wb_en | output | 1 | Write `out_addr` back to the base register |
| out_illegal | output | 1 | The operation encodes an illegal form |

## Verification
The hardest situation to create from the ports is a new operation arriving on the same edge that a stalled request is released. This case exercises the pass-through path of `in_ready` and the overwrite of the output register in one cycle. The stimulus lowers `out_ready` in about a third of the cycles and keeps `in_valid` high most of the time, so stalls, releases and back-to-back transfers happen repeatedly. Random unaligned addresses and negative displacements push the address wrap and the low-bit masking. The reference model writes the bytes into a plain eight-byte memory image, which it then maps onto lanes.

// File: rtl/stu_pkg.sv
package stu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    FM_DISP      = 3'd0,
    FM_INDEX     = 3'd1,
    FM_UPD_DISP  = 3'd2,
    FM_UPD_INDEX = 3'd3,
    FM_REV_INDEX = 3'd4
  } form_e;

  typedef struct packed {
    logic  use_rb;
    logic  update;
    logic  reverse;
    logic  illegal;
    size_e size;
  } ctl_t;

endpackage

// File: rtl/stu_decode.sv
module stu_decode
  import stu_pkg::*;
(
  input  logic [4:0] op,
  input  logic       ra_zero,
  output ctl_t       ctl
);

  logic [2:0] form;

  assign form = op[4:2];

  always_comb begin
    ctl         = '0;
    ctl.size    = size_e'(op[1:0]);
    case (form)
      FM_DISP: begin
      end
      FM_INDEX: begin
        ctl.use_rb = 1'b1;
      end
      FM_UPD_DISP: begin
        ctl.update  = 1'b1;
        ctl.illegal = ra_zero;
      end
      FM_UPD_INDEX: begin
        ctl.use_rb  = 1'b1;
        ctl.update  = 1'b1;
        ctl.illegal = ra_zero;
      end
      FM_REV_INDEX: begin
        ctl.use_rb  = 1'b1;
        ctl.reverse = 1'b1;
        ctl.illegal = (op[1:0] == SZ_BYTE);
      end
      default: begin
        ctl.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/stu_agen.sv
module stu_agen
  import stu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DISP_W = 16
) (
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DISP_W-1:0] disp,
  input  logic              ra_zero,
  input  ctl_t              ctl,
  output logic [DATA_W-1:0] ea
);

  localparam int unsigned EXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] base;
  logic [DISP_W-1:0] disp_eff;
  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] offset;

  always_comb begin
    base = (ra_zero && !ctl.update) ? '0 : ra_val;

    disp_eff = disp;
    if (ctl.size == SZ_DWORD) begin
      disp_eff[1:0] = 2'b00;
    end

    disp_ext = {{EXT_W{disp_eff[DISP_W-1]}}, disp_eff};
    offset   = ctl.use_rb ? rb_val : disp_ext;
    ea       = base + offset;
  end

endmodule

// File: rtl/stu_lane.sv
module stu_lane
  import stu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] rs_val,
  input  ctl_t              ctl,
  input  logic [OFF_W-1:0]  ea_low,
  output logic [NB-1:0]     be,
  output logic [DATA_W-1:0] data
);

  int nbytes;
  int lane_off;

  always_comb begin
    nbytes   = 1 << int'(ctl.size);
    lane_off = int'(ea_low) & ~(nbytes - 1);
    be       = '0;
    data     = '0;
    for (int k = 0; k < int'(NB); k++) begin
      if (k < nbytes && !ctl.illegal) begin
        if (ctl.reverse) begin
          data[(int'(NB) - 1 - lane_off - k)*8 +: 8] = rs_val[k*8 +: 8];
        end else begin
          data[(int'(NB) - 1 - lane_off - k)*8 +: 8] = rs_val[(nbytes - 1 - k)*8 +: 8];
        end
        be[int'(NB) - 1 - lane_off - k] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stu_top.sv
module stu_top
  import stu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DISP_W = 16,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DATA_W-1:0] rs_val,
  input  logic              ra_zero,
  input  logic [DISP_W-1:0] disp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_addr,
  output logic [NB-1:0]     out_be,
  output logic [DATA_W-1:0] out_data,
  output logic              out_wb_en,
  output logic              out_illegal
);

  ctl_t              ctl;
  logic [DATA_W-1:0] ea;
  logic [NB-1:0]     lane_be;
  logic [DATA_W-1:0] lane_data;
  logic              accept;
  logic              valid_nxt;
  logic              load_en;

  stu_decode u_decode (
    .op      (op),
    .ra_zero (ra_zero),
    .ctl     (ctl)
  );

  stu_agen #(
    .DATA_W (DATA_W),
    .DISP_W (DISP_W)
  ) u_agen (
    .ra_val  (ra_val),
    .rb_val  (rb_val),
    .disp    (disp),
    .ra_zero (ra_zero),
    .ctl     (ctl),
    .ea      (ea)
  );

  stu_lane #(
    .DATA_W (DATA_W)
  ) u_lane (
    .rs_val (rs_val),
    .ctl    (ctl),
    .ea_low (ea[OFF_W-1:0]),
    .be     (lane_be),
    .data   (lane_data)
  );

  always_comb begin
    in_ready  = !out_valid || out_ready;
    accept    = in_valid && in_ready;
    load_en   = accept;
    valid_nxt = accept ? 1'b1 : (out_ready ? 1'b0 : out_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr    <= '0;
      out_be      <= '0;
      out_data    <= '0;
      out_wb_en   <= 1'b0;
      out_illegal <= 1'b0;
    end else if (load_en) begin
      out_addr    <= ea;
      out_be      <= lane_be;
      out_data    <= lane_data;
      out_wb_en   <= ctl.update && !ctl.illegal;
      out_illegal <= ctl.illegal;
    end
  end

endmodule

// File: rtl/stu_checker.sv
module stu_checker #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NB    = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_addr,
  input logic [NB-1:0]     out_be,
  input logic [DATA_W-1:0] out_data,
  input logic              out_wb_en,
  input logic              out_illegal
);

  logic [DATA_W-1:0] be_mask;

  always_comb begin
    be_mask = '0;
    for (int i = 0; i < int'(NB); i++) begin
      be_mask[i*8 +: 8] = {8{out_be[i]}};
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
      && $stable(out_data) && $stable(out_wb_en) && $stable(out_illegal)); // R8

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_be == '0 && !out_wb_en && out_data == '0); // R5

  AST_BE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> $countones(out_be) == 1 || $countones(out_be) == 2
      || $countones(out_be) == 4 || $countones(out_be) == 8); // R6

  AST_DATA_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data & ~be_mask) == '0); // R6

  AST_WB_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> !out_illegal); // R4

endmodule

bind stu_top stu_checker #(.DATA_W(DATA_W)) u_stu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_be      (out_be),
  .out_data    (out_data),
  .out_wb_en   (out_wb_en),
  .out_illegal (out_illegal)
);

// File: tb/stu_top_test.sv
`timescale 1ns/1ps
module stu_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [4:0]  op;
  logic [63:0] ra_val, rb_val, rs_val;
  logic        ra_zero;
  logic [15:0] disp;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_addr;
  logic [7:0]  out_be;
  logic [63:0] out_data;
  logic        out_wb_en;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected output register contents
  bit          m_valid = 0;
  logic [63:0] e_addr;
  logic [7:0]  e_be;
  logic [63:0] e_data;
  bit          e_wb, e_ill;
  string       t_addr, t_be, t_data;

  always #2.5 clk = ~clk;

  stu_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .ra_val(ra_val), .rb_val(rb_val), .rs_val(rs_val),
    .ra_zero(ra_zero), .disp(disp), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_be(out_be), .out_data(out_data),
    .out_wb_en(out_wb_en), .out_illegal(out_illegal)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference: writes bytes into an 8-byte memory image, then maps it to lanes.
  task automatic model(input logic [4:0] o, input logic [63:0] ra, input logic [63:0] rb,
                       input logic [63:0] rs, input bit raz, input logic [15:0] d);
    int form = int'(o[4:2]);
    int sz = int'(o[1:0]);
    int n = 1 << sz;
    bit upd = (form == 2) || (form == 3);
    bit idx = (form == 1) || (form == 3) || (form == 4);
    bit rev = (form == 4);
    bit ill = (upd && raz) || (form > 4) || (rev && sz == 0);
    logic [63:0] base, off, ea;
    logic [7:0] mem [8];
    bit wr [8];
    int lo;
    base = (upd || !raz) ? ra : 64'd0;                       // R1
    if (idx) off = rb;
    else begin
      off = {{48{d[15]}}, d};
      if (sz == 3) off = off & ~64'd3;                        // R3
    end
    ea = base + off;                                          // R2
    for (int i = 0; i < 8; i++) begin mem[i] = 8'h00; wr[i] = 0; end
    lo = int'(ea[2:0]) & ~(n - 1);                            // R10
    if (!ill) begin
      for (int k = 0; k < n; k++) begin
        mem[lo + k] = rev ? rs[8*k +: 8] : rs[8*(n-1-k) +: 8];  // R6 R7
        wr[lo + k] = 1;
      end
    end
    e_addr = ea;
    for (int i = 0; i < 8; i++) begin
      e_data[8*i +: 8] = mem[7 - i];
      e_be[i] = wr[7 - i];
    end
    e_wb  = upd && !ill;
    e_ill = ill;
    t_addr = (!upd && raz) ? "R1" : ((!idx && sz == 3) ? "R3" : "R2");
    t_be   = (ea[2:0] != 3'(lo)) ? "R10" : "R6";
    t_data = rev ? "R7" : "R6";
  endtask

  task automatic pick(input int cyc);
    int f;
    ra_val = {$urandom, $urandom};
    rb_val = {$urandom, $urandom};
    rs_val = {$urandom, $urandom};
    disp   = 16'($urandom);
    ra_zero = ($urandom % 4) == 0;
    in_valid = ($urandom % 8) != 0;
    out_ready = ($urandom % 3) != 0;
    f = (($urandom % 10) < 9) ? int'($urandom % 5) : 5 + int'($urandom % 3);
    op = {3'(f), 2'($urandom)};
    case (cyc)
      0: begin op = 5'b000_11; ra_val = 64'h10; ra_zero = 0; disp = 16'hFFF7; in_valid = 1; end // negative DS, low bits dropped
      1: begin op = 5'b010_00; ra_zero = 1; in_valid = 1; end  // update with zero base
      2: begin op = 5'b100_00; in_valid = 1; end                // reversed byte
      3: begin op = 5'b100_11; ra_zero = 1; rb_val = 64'h8; rs_val = 64'h0102030405060708; in_valid = 1; end
      4: begin op = 5'b001_01; ra_zero = 0; ra_val = 64'hFFFF_FFFF_FFFF_FFFF; rb_val = 64'h3; in_valid = 1; end
      5: begin op = 5'b011_10; ra_zero = 0; in_valid = 1; out_ready = 0; end
      6: begin op = 5'b000_00; ra_zero = 1; disp = 16'h8005; in_valid = 1; out_ready = 0; end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    rst_n = 0; in_valid = 0; out_ready = 0; op = '0; ra_val = '0; rb_val = '0;
    rs_val = '0; ra_zero = 0; disp = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      chk(out_valid == m_valid, "R8", "out_valid", 64'(out_valid), 64'(m_valid));
      chk(in_ready == (!m_valid || out_ready), "R8", "in_ready", 64'(in_ready),
          64'(!m_valid || out_ready));
      if (m_valid && out_valid) begin
        chk(out_addr == e_addr, t_addr, "address", out_addr, e_addr);
        chk(out_be == e_be, t_be, "byte enables", 64'(out_be), 64'(e_be));
        chk(out_data == e_data, t_data, "write data", out_data, e_data);
        chk(out_wb_en == e_wb, "R4", "write-back", 64'(out_wb_en), 64'(e_wb));
        chk(out_illegal == e_ill, "R5", "illegal flag", 64'(out_illegal), 64'(e_ill));
      end
      pick(cyc);
      acc = in_valid && (!m_valid || out_ready);
      if (acc) begin
        model(op, ra_val, rb_val, rs_val, ra_zero, disp);
        m_valid = 1;
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule